// File: doc/BRIEF.md
# Two-level interrupt masking controller

This block gathers level-sensitive interrupt sources for up to four CPUs and decides, per CPU, which of them is currently deliverable. Every source must pass two gates before a CPU sees it: a single global enable bit shared by all CPUs, and a mask bit private to each CPU. Both gates are changed by writing a source number to a dedicated set or clear register, so software never does a read-modify-write of a wide bit vector.

Sources fall into two groups. Low-numbered sources (below `PCPU`, default 29) are private: each CPU has its own input line for them and no routing applies. Higher-numbered sources are shared: one input line is steered to CPUs by a per-source route word holding one normal-delivery bit and one fast-delivery bit per CPU. Sources 0 and 1 are kept for internal summaries and never become pending. Each CPU reads an acknowledge register to learn the lowest-numbered deliverable source, and a cause register showing its raw private inputs.

Register access uses a write port and a separate read port. Reads are answered one cycle later by a two-state machine: `BUS_IDLE` moves to `BUS_RESP` on a read request, `BUS_RESP` stays while requests keep coming and returns to `BUS_IDLE` on a cycle without one.

Top module: `irqm_top`

## Requirements
- R1: After reset every global enable is 0, every per-CPU mask is 1, every route word reads 0, `irq_out` is 0 and every acknowledge read returns 0x3FF.
- R2: A global write of index N (data bits 10:0) to offset 0x010 sets the enable of source N and to offset 0x014 clears it; an index of `NSRC` or more changes no enable.
- R3: A private write of index N to offset 0x030 masks source N only for the CPU given on `wr_cpu`, and to offset 0x034 unmasks it only for that CPU; the other CPUs' masks are unchanged.
- R4: A shared source S (S >= `PCPU`) is pending for CPU c exactly when `sh_irq[S]` is 1, its enable is 1, it is unmasked for c, and bit c or bit 8+c of its route word is 1. The route word is written and read at global offset 0x400 + 4*S; bits 3:0 are the normal bits, bits 11:8 the fast bits, all other bits read 0.
- R5: A private source S (2 <= S < `PCPU`) is pending for CPU c exactly when `pcpu_irq[c*PCPU+S]` is 1, its enable is 1 and it is unmasked for c; its route word ignores writes and reads 0.
- R6: Sources 0 and 1 are never pending for any CPU, whatever their inputs, enables and masks, and never appear in the cause register.
- R7: A private read of offset 0x020 returns, in bits 9:0, the lowest-numbered source pending for the reading CPU, or 0x3FF when none is; bits 31:10 are 0. `rd_valid` is 1 exactly in the cycle after a cycle with `rd_en` high, and `rd_data` then holds the answer.
- R8: A private read of offset 0x000 returns, in bits 2 to `PCPU`-1, the raw private inputs of the reading CPU, independent of enables and masks; all other bits are 0.
- R9: A global read of offset 0x000 returns `NSRC` in bits 12:2 and 0 elsewhere.
- R10: `irq_out[c]` is 1 exactly when at least one source is pending for CPU c, in the same cycle as the inputs and stored gates.
- R11: Pending state is not latched: when a source's input drops, it stops being pending in that same cycle.
- R12: When a write and a read occur in the same cycle, the read answer reflects the state before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_priv | input | 1 | 1 selects the private window of `wr_cpu`, 0 the global window |
| wr_cpu | input | 2 | CPU issuing the write |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data (source index or route word) |
| rd_en | input | 1 | Read request |
| rd_priv | input | 1 | 1 selects the private window of `rd_cpu`, 0 the global window |
| rd_cpu | input | 2 | CPU issuing the read |
| rd_addr | input | 12 | Read byte offset |
| rd_valid | output | 1 | Read answer valid, one cycle after the request |
| rd_data | output | 32 | Read answer |
| sh_irq | input | NSRC | Shared source levels; bits below `PCPU` are ignored |
| pcpu_irq | input | NCPU*PCPU | Private source levels, CPU c at bits c*PCPU upward |
| irq_out | output | NCPU | Per-CPU interrupt request |

## Verification
The delicate collision is a gate write and an acknowledge read landing on the same clock edge: the bench unmasks a source that is already raised, enabled and routed while the same CPU reads its acknowledge register in that cycle, and expects 0x3FF, then the source number on the next read. A second overlap is an input dropping while another, lower-priority source stays pending, which must move the acknowledge answer immediately. A behavioural model of gates, routes and levels predicts `irq_out` for every CPU on every clock.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
    localparam int IDX_W  = 11;
    localparam int ID_W   = 10;
    localparam int ADDR_W = 12;

    localparam logic [ID_W-1:0] ID_NONE = '1;

    // global window
    localparam logic [ADDR_W-1:0] GA_INFO   = 12'h000;
    localparam logic [ADDR_W-1:0] GA_EN_SET = 12'h010;
    localparam logic [ADDR_W-1:0] GA_EN_CLR = 12'h014;
    localparam logic [ADDR_W-1:0] GA_ROUTE  = 12'h400;

    // private window
    localparam logic [ADDR_W-1:0] PA_CAUSE  = 12'h000;
    localparam logic [ADDR_W-1:0] PA_ACK    = 12'h020;
    localparam logic [ADDR_W-1:0] PA_MSET   = 12'h030;
    localparam logic [ADDR_W-1:0] PA_MCLR   = 12'h034;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;
endpackage

// File: rtl/irqm_gates.sv
module irqm_gates
    import irqm_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int NCPU = 4,
    parameter int PCPU = 29
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             en_set,
    input  logic                             en_clr,
    input  logic                             msk_set,
    input  logic                             msk_clr,
    input  logic [1:0]                       cpu,
    input  logic [IDX_W-1:0]                 idx,
    input  logic                             rt_wr,
    input  logic [IDX_W-1:0]                 rt_idx,
    input  logic [2*NCPU-1:0]                rt_data,
    output logic [NSRC-1:0]                  en_q,
    output logic [NCPU-1:0][NSRC-1:0]        mask_q,
    output logic [NSRC-1:0][2*NCPU-1:0]      route_q
);
    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int RW = 2 * NCPU;

    logic          idx_ok;
    logic [SW-1:0] sel;

    assign idx_ok = int'(idx) < NSRC;
    assign sel    = idx[SW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (idx_ok) begin
            if (en_set) begin
                en_q[sel] <= 1'b1;
            end else if (en_clr) begin
                en_q[sel] <= 1'b0;
            end
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NSRC-1:0] m;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m <= '1;
            end else if (idx_ok && int'(cpu) == c) begin
                if (msk_set) begin
                    m[sel] <= 1'b1;
                end else if (msk_clr) begin
                    m[sel] <= 1'b0;
                end
            end
        end
        assign mask_q[c] = m;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_rt
        if (s < PCPU) begin : g_none
            assign route_q[s] = '0;
        end else begin : g_reg
            logic [RW-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= '0;
                end else if (rt_wr && int'(rt_idx) == s) begin
                    r <= rt_data;
                end
            end
            assign route_q[s] = r;
        end
    end
endmodule

// File: rtl/irqm_pick.sv
module irqm_pick
    import irqm_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int NCPU = 4,
    parameter int PCPU = 29
) (
    input  logic [NSRC-1:0]             en_q,
    input  logic [NCPU-1:0][NSRC-1:0]   mask_q,
    input  logic [NSRC-1:0][2*NCPU-1:0] route_q,
    input  logic [NSRC-1:0]             sh_irq,
    input  logic [NCPU-1:0][PCPU-1:0]   pc_irq,
    output logic [NCPU-1:0]             pend_any,
    output logic [NCPU-1:0][ID_W-1:0]   pend_id
);
    logic unused_g;
    assign unused_g = ^{sh_irq[PCPU-1:0], en_q[1:0], route_q[PCPU-1:0]};

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NSRC-1:0] pv;
        logic [ID_W-1:0] id;
        logic            unused_pc;

        assign unused_pc = ^{pc_irq[c][1:0], mask_q[c][1:0]};

        for (genvar s = 0; s < NSRC; s++) begin : g_src
            if (s < 2) begin : g_rsv
                assign pv[s] = 1'b0;
            end else if (s < PCPU) begin : g_prv
                assign pv[s] = pc_irq[c][s] & en_q[s] & ~mask_q[c][s];
            end else begin : g_shr
                assign pv[s] = sh_irq[s] & en_q[s] & ~mask_q[c][s]
                             & (route_q[s][c] | route_q[s][NCPU+c]);
            end
        end

        always_comb begin
            id = ID_NONE;
            for (int s = NSRC - 1; s >= 0; s--) begin
                if (pv[s]) begin
                    id = ID_W'(s);
                end
            end
        end

        assign pend_any[c] = |pv;
        assign pend_id[c]  = id;
    end
endmodule

// File: rtl/irqm_top.sv
module irqm_top
    import irqm_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int NCPU = 4,
    parameter int PCPU = 29
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_priv,
    input  logic [1:0]           wr_cpu,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic                 rd_en,
    input  logic                 rd_priv,
    input  logic [1:0]           rd_cpu,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    input  logic [NSRC-1:0]      sh_irq,
    input  logic [NCPU*PCPU-1:0] pcpu_irq,
    output logic [NCPU-1:0]      irq_out
);
    localparam int RW = 2 * NCPU;

    logic [NSRC-1:0]            en_q;
    logic [NCPU-1:0][NSRC-1:0]  mask_q;
    logic [NSRC-1:0][RW-1:0]    route_q;
    logic [NCPU-1:0][PCPU-1:0]  pc2;
    logic [NCPU-1:0][ID_W-1:0]  pend_id;

    logic [ADDR_W-1:0] w_off, r_off;
    logic              w_rt, r_rt;
    logic [IDX_W-1:0]  w_ridx, r_ridx;
    logic              wr_cpu_ok;
    logic              unused_wd;

    assign pc2       = pcpu_irq;
    assign wr_cpu_ok = int'(wr_cpu) < NCPU;
    assign unused_wd = ^wr_data[31:12];

    assign w_off  = wr_addr - GA_ROUTE;
    assign r_off  = rd_addr - GA_ROUTE;
    assign w_rt   = (wr_addr >= GA_ROUTE) && (wr_addr[1:0] == 2'b00);
    assign r_rt   = (rd_addr >= GA_ROUTE) && (rd_addr[1:0] == 2'b00);
    assign w_ridx = IDX_W'(w_off[ADDR_W-1:2]);
    assign r_ridx = IDX_W'(r_off[ADDR_W-1:2]);

    irqm_gates #(.NSRC(NSRC), .NCPU(NCPU), .PCPU(PCPU)) u_gates (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_set  (wr_en && !wr_priv && wr_addr == GA_EN_SET),
        .en_clr  (wr_en && !wr_priv && wr_addr == GA_EN_CLR),
        .msk_set (wr_en && wr_priv && wr_cpu_ok && wr_addr == PA_MSET),
        .msk_clr (wr_en && wr_priv && wr_cpu_ok && wr_addr == PA_MCLR),
        .cpu     (wr_cpu),
        .idx     (wr_data[IDX_W-1:0]),
        .rt_wr   (wr_en && !wr_priv && w_rt),
        .rt_idx  (w_ridx),
        .rt_data ({wr_data[8+:NCPU], wr_data[NCPU-1:0]}),
        .en_q    (en_q),
        .mask_q  (mask_q),
        .route_q (route_q)
    );

    irqm_pick #(.NSRC(NSRC), .NCPU(NCPU), .PCPU(PCPU)) u_pick (
        .en_q     (en_q),
        .mask_q   (mask_q),
        .route_q  (route_q),
        .sh_irq   (sh_irq),
        .pc_irq   (pc2),
        .pend_any (irq_out),
        .pend_id  (pend_id)
    );

    // read answer, taken from the state before this cycle's write
    logic [31:0] rd_word;
    always_comb begin
        rd_word = '0;
        if (rd_priv) begin
            for (int c = 0; c < NCPU; c++) begin
                if (int'(rd_cpu) == c) begin
                    if (rd_addr == PA_CAUSE) begin
                        for (int s = 2; s < PCPU; s++) begin
                            rd_word[s] = pc2[c][s];
                        end
                    end else if (rd_addr == PA_ACK) begin
                        rd_word[ID_W-1:0] = pend_id[c];
                    end
                end
            end
        end else if (rd_addr == GA_INFO) begin
            rd_word = {19'b0, IDX_W'(NSRC), 2'b00};
        end else if (r_rt) begin
            for (int s = PCPU; s < NSRC; s++) begin
                if (int'(r_ridx) == s) begin
                    rd_word[NCPU-1:0] = route_q[s][NCPU-1:0];
                    rd_word[8+:NCPU]  = route_q[s][NCPU+:NCPU];
                end
            end
        end
    end

    // read response state machine
    bus_state_e  st_q, st_d;
    logic [31:0] rd_data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= BUS_IDLE;
            rd_data_q <= '0;
        end else begin
            st_q <= st_d;
            if (rd_en) begin
                rd_data_q <= rd_word;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: if (rd_en)  st_d = BUS_RESP;
            BUS_RESP: if (!rd_en) st_d = BUS_IDLE;
            default:  st_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        rd_valid = (st_q == BUS_RESP);
        rd_data  = rd_data_q;
    end
endmodule

// File: rtl/irqm_chk.sv
module irqm_chk
    import irqm_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int NCPU = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic                       wr_priv,
    input logic [1:0]                 wr_cpu,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [31:0]                wr_data,
    input logic                       rd_en,
    input logic                       rd_priv,
    input logic [ADDR_W-1:0]          rd_addr,
    input logic                       rd_valid,
    input logic [31:0]                rd_data,
    input logic [NCPU-1:0]            irq_out,
    input logic [NSRC-1:0]            en_q,
    input logic [NCPU-1:0][NSRC-1:0]  mask_q
);
    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic          idx_ok;
    logic [SW-1:0] sel;
    logic          ack_rd;
    logic          unused_chk;

    assign idx_ok     = int'(wr_data[IDX_W-1:0]) < NSRC;
    assign sel        = wr_data[SW-1:0];
    assign ack_rd     = rd_en && rd_priv && rd_addr == PA_ACK;
    assign unused_chk = ^wr_data[31:IDX_W];

    // R7
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R7
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R6
    ack_id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd |=> (rd_data[31:ID_W] == '0) &&
                   ((rd_data[ID_W-1:0] == ID_NONE) ||
                    (rd_data[ID_W-1:0] >= 2 && int'(rd_data[ID_W-1:0]) < NSRC)));

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv && wr_addr == GA_EN_SET && idx_ok) |=> en_q[$past(sel)]);

    // R2
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv && wr_addr == GA_EN_CLR && idx_ok) |=> !en_q[$past(sel)]);

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_priv && wr_addr == PA_MSET && idx_ok) |=> mask_q[$past(wr_cpu)][$past(sel)]);

    // R3
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_priv && wr_addr == PA_MCLR && idx_ok) |=> !mask_q[$past(wr_cpu)][$past(sel)]);

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> (en_q != '0));
endmodule

bind irqm_top irqm_chk #(.NSRC(NSRC), .NCPU(NCPU)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_priv  (wr_priv),
    .wr_cpu   (wr_cpu),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_priv  (rd_priv),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .irq_out  (irq_out),
    .en_q     (en_q),
    .mask_q   (mask_q)
);

// File: tb/irqm_top_test.sv
`timescale 1ns/1ps
module irqm_top_test;
    localparam int NSRC = 64;
    localparam int NCPU = 4;
    localparam int PCPU = 29;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0, wr_priv = 1'b0;
    logic [1:0]           wr_cpu = '0;
    logic [11:0]          wr_addr = '0;
    logic [31:0]          wr_data = '0;
    logic                 rd_en = 1'b0, rd_priv = 1'b0;
    logic [1:0]           rd_cpu = '0;
    logic [11:0]          rd_addr = '0;
    logic                 rd_valid;
    logic [31:0]          rd_data;
    logic [NSRC-1:0]      sh_irq = '0;
    logic [NCPU*PCPU-1:0] pcpu_irq = '0;
    logic [NCPU-1:0]      irq_out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  cmp_on = 1'b0;
    bit  done = 1'b0;

    // behavioural reference state
    bit          m_en   [NSRC];
    bit          m_mask [NCPU][NSRC];
    logic [31:0] m_route[NSRC];

    always #2 clk = ~clk;

    irqm_top #(.NSRC(NSRC), .NCPU(NCPU), .PCPU(PCPU)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_priv(wr_priv), .wr_cpu(wr_cpu), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_priv(rd_priv), .rd_cpu(rd_cpu), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .sh_irq(sh_irq), .pcpu_irq(pcpu_irq), .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit m_pend(int c, int s);
        if (s < 2) return 1'b0;
        if (!m_en[s] || m_mask[c][s]) return 1'b0;
        if (s < PCPU) return pcpu_irq[c*PCPU+s];
        return sh_irq[s] && (m_route[s][c] || m_route[s][8+c]);
    endfunction

    task automatic m_reset();
        for (int s = 0; s < NSRC; s++) begin
            m_en[s] = 1'b0;
            m_route[s] = '0;
            for (int c = 0; c < NCPU; c++) m_mask[c][s] = 1'b1;
        end
    endtask

    task automatic m_write(input bit p, input int c, input int a, input int d);
        int i;
        i = d & 32'h7FF;
        if (!p) begin
            if (a == 'h010 && i < NSRC) m_en[i] = 1'b1;
            if (a == 'h014 && i < NSRC) m_en[i] = 1'b0;
            if (a >= 'h400 && (a % 4) == 0) begin
                int r;
                r = (a - 'h400) / 4;
                if (r >= PCPU && r < NSRC) m_route[r] = d & 32'h0F0F;
            end
        end else if (c < NCPU && i < NSRC) begin
            if (a == 'h030) m_mask[c][i] = 1'b1;
            if (a == 'h034) m_mask[c][i] = 1'b0;
        end
    endtask

    // R10: every clock, irq_out against the reference
    always @(negedge clk) begin
        #1;
        if (cmp_on) begin
            for (int c = 0; c < NCPU; c++) begin
                bit e;
                e = 1'b0;
                for (int s = 0; s < NSRC; s++) e |= m_pend(c, s);
                chk(irq_out[c] === e, $sformatf("R10 irq_out[%0d]", c), 32'(irq_out[c]), 32'(e));
            end
        end
    end

    task automatic wr(input bit p, input int c, input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_priv = p; wr_cpu = c[1:0]; wr_addr = a[11:0]; wr_data = d;
        @(posedge clk); #1;
        m_write(p, c, a, d);
        wr_en = 1'b0;
    endtask

    task automatic rd(input bit p, input int c, input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; rd_priv = p; rd_cpu = c[1:0]; rd_addr = a[11:0];
        @(posedge clk); #1;
        rd_en = 1'b0;
        chk(rd_valid === 1'b1 && rd_data === exp, req, rd_data, exp);
    endtask

    task automatic wr_rd(input int wc, input int wa, input int wd, input int rc, input int ra,
                         input logic [31:0] exp, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_priv = 1'b1; wr_cpu = wc[1:0]; wr_addr = wa[11:0]; wr_data = wd;
        rd_en = 1'b1; rd_priv = 1'b1; rd_cpu = rc[1:0]; rd_addr = ra[11:0];
        @(posedge clk); #1;
        m_write(1'b1, wc, wa, wd);
        wr_en = 1'b0; rd_en = 1'b0;
        chk(rd_valid === 1'b1 && rd_data === exp, req, rd_data, exp);
    endtask

    task automatic set_sh(input int s, input bit v);
        @(negedge clk);
        sh_irq[s] = v;
    endtask

    task automatic set_pc(input int c, input int s, input bit v);
        @(negedge clk);
        pcpu_irq[c*PCPU+s] = v;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk); #1;
        chk(irq_out === '0, "R1 irq_out after reset", 32'(irq_out), 0);
        chk(rd_valid === 1'b0, "R7 no answer without request", 32'(rd_valid), 0);
        for (int c = 0; c < NCPU; c++) rd(1, c, 'h020, 32'h3FF, "R1 ack idle");
        rd(0, 0, 'h4A0, 32'h0, "R1 route word cleared");
        rd(0, 0, 'h000, 32'h100, "R9 source count");

        // R4 shared routing
        set_sh(40, 1'b1);
        wr(0, 0, 'h4A0, 'h002);
        wr(1, 1, 'h034, 40);
        rd(1, 1, 'h020, 32'h3FF, "R4 not yet enabled");
        wr(0, 0, 'h010, 40);
        rd(1, 1, 'h020, 32'd40, "R4 enabled routed unmasked");
        rd(1, 0, 'h020, 32'h3FF, "R4 cpu0 not routed");
        wr(0, 0, 'h4A0, 'h102);
        rd(1, 0, 'h020, 32'h3FF, "R3 cpu0 still masked");
        wr(1, 0, 'h034, 40);
        rd(1, 0, 'h020, 32'd40, "R4 fast bit routes");
        rd(0, 0, 'h4A0, 32'h102, "R4 route readback");

        // R3 per-CPU masks
        wr(1, 1, 'h030, 40);
        rd(1, 1, 'h020, 32'h3FF, "R3 cpu1 masked");
        rd(1, 0, 'h020, 32'd40, "R3 cpu0 unaffected");

        // R2 global enable
        wr(0, 0, 'h014, 40);
        rd(1, 0, 'h020, 32'h3FF, "R2 enable cleared");
        wr(0, 0, 'h010, 104);
        rd(1, 0, 'h020, 32'h3FF, "R2 out-of-range index ignored");
        wr(0, 0, 'h010, 40);
        rd(1, 0, 'h020, 32'd40, "R2 enable set again");

        // R5 private sources
        set_pc(3, 5, 1'b1);
        wr(0, 0, 'h010, 5);
        wr(1, 3, 'h034, 5);
        rd(1, 3, 'h020, 32'd5, "R5 private source");
        wr(0, 0, 'h414, 'h00F);
        rd(0, 0, 'h414, 32'h0, "R5 private route ignored");
        wr(1, 2, 'h034, 5);
        rd(1, 2, 'h020, 32'h3FF, "R5 other cpu input low");

        // R7 priority, R11 level
        set_pc(0, 3, 1'b1);
        wr(0, 0, 'h010, 3);
        wr(1, 0, 'h034, 3);
        rd(1, 0, 'h020, 32'd3, "R7 lowest wins");
        set_sh(30, 1'b1);
        wr(0, 0, 'h478, 'h001);
        wr(0, 0, 'h010, 30);
        wr(1, 0, 'h034, 30);
        rd(1, 0, 'h020, 32'd3, "R7 lower private beats shared");
        set_pc(0, 3, 1'b0);
        rd(1, 0, 'h020, 32'd30, "R11 private level dropped");
        set_sh(30, 1'b0);
        rd(1, 0, 'h020, 32'd40, "R11 shared level dropped");

        // R6 reserved sources
        set_pc(3, 0, 1'b1);
        set_pc(3, 1, 1'b1);
        set_sh(0, 1'b1);
        set_sh(1, 1'b1);
        wr(0, 0, 'h010, 0);
        wr(0, 0, 'h010, 1);
        wr(1, 3, 'h034, 0);
        wr(1, 3, 'h034, 1);
        rd(1, 3, 'h020, 32'd5, "R6 reserved never pending");

        // R8 cause
        set_pc(3, 28, 1'b1);
        set_pc(3, 10, 1'b1);
        rd(1, 3, 'h000, 32'h1000_0420, "R8 raw private inputs");
        rd(1, 1, 'h000, 32'h0, "R8 idle cpu cause");

        // R12 write/read collision
        set_sh(50, 1'b1);
        wr(0, 0, 'h4C8, 'h004);
        wr(0, 0, 'h010, 50);
        rd(1, 2, 'h020, 32'h3FF, "R12 masked before");
        wr_rd(2, 'h034, 50, 2, 'h020, 32'h3FF, "R12 read sees pre-write state");
        rd(1, 2, 'h020, 32'd50, "R12 write visible next");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule